// File: doc/BRIEF.md
# Deep-Sleep Power Sequencer

This controller decides when the chip drops into its deepest low-power state and how it climbs back out. It watches the processor's sleep request and mode code together with the status flags of a companion radio. The deep state is granted only when both subsystems are asleep at once and the ADC is switched off. While the chip is in the deep state, the sequencer turns off the main digital and analog regulator enables, puts the SRAM into retention and gates off every high-frequency clock enable. Only the always-on low-leakage domain keeps running, on a slow clock.

An enabled wake source ends the deep state. The sequencer then switches the digital regulator back on and waits for a power-good handshake from the chain, guarded by a programmable timeout. After that it releases SRAM retention and hands control to the normal wake sequence. A status flag tells software whether the last wake came from the deep state or from an ordinary sleep, so that the longer latency can be accounted for. Requests for other sleep modes, or requests made while the radio is still awake, give an ordinary sleep that keeps the regulators on.

Top module: `dsp_deep_sleep_seq`

## Requirements
- R1: After the asynchronous active-low reset the block is active: `dvdd_en`, `avdd_en` and `hf_clk_en` are 1, and `sram_retain`, `asleep`, `deep_sleep`, `reject_err`, `adc_err`, `pg_fault`, `wake_done` and `wake_was_deep` are 0.
- R2: A `sleep_req` sampled while active with `sleep_mode` 3'b010 (power-down) or 3'b011 (power-save), `radio_sleep`=1, `radio_waking`=0 and `adc_en`=0 enters the deep state at that edge. From then on `deep_sleep`=1, `asleep`=1, `dvdd_en`=0, `avdd_en`=0, `sram_retain`=1 and `hf_clk_en`=0.
- R3: A request with any other mode code (including 3'b000, idle), or a deep-mode request while `radio_sleep`=0, gives an ordinary sleep. In it `asleep`=1, while `dvdd_en`, `avdd_en` and `hf_clk_en` stay 1 and `sram_retain` stays 0.
- R4: A deep-mode request sampled while `radio_waking`=1 is refused. The block stays active and `reject_err` becomes 1. `reject_err` stays 1 until the first edge that samples `radio_waking`=0, and is 0 after that edge.
- R5: A deep-mode request that would otherwise enter the deep state, but is sampled with `adc_en`=1, is refused. The block stays active and `adc_err` becomes 1. `adc_err` stays 1 until reset.
- R6: A sleep, ordinary or deep, ends only at an edge where some bit of `wake_src & wake_en` is 1. A source whose `wake_en` bit is 0 is ignored.
- R7: One cycle after a wake from the deep state, `dvdd_en` is 1. `sram_retain` stays 1, and `avdd_en` and `hf_clk_en` stay 0, for as long as `pg_ok` is sampled 0.
- R8: An edge that samples `pg_ok`=1 during the restart clears `sram_retain` while `dvdd_en` stays 1. One edge later the block is active, with `avdd_en`=1, `hf_clk_en`=1 and a one-cycle `wake_done` pulse.
- R9: If `pg_ok` is sampled 0 on `pg_limit` consecutive restart edges, the block enters a fault state. There `pg_fault`=1, `sram_retain`=1 and `hf_clk_en`=0, and the fault holds until reset. A `pg_ok` on the edge numbered `pg_limit` (the next one) still succeeds.
- R10: `wake_done` pulses for one cycle on every return to active from sleep. `wake_was_deep` is 1 after a deep wake and 0 after an ordinary wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Processor sleep request, sampled while active |
| sleep_mode | input | 3 | Requested sleep mode code |
| radio_sleep | input | 1 | Radio is in its sleep state |
| radio_waking | input | 1 | Radio is in its wake-up phase |
| wake_src | input | NWAKE | Wake source events |
| wake_en | input | NWAKE | Per-source wake enables |
| adc_en | input | 1 | ADC is enabled |
| pg_ok | input | 1 | Power chain reports fully enabled |
| pg_limit | input | PG_W | Restart timeout in cycles |
| dvdd_en | output | 1 | Main digital regulator enable |
| avdd_en | output | 1 | Analog regulator enable |
| sram_retain | output | 1 | SRAM data-retention control |
| hf_clk_en | output | 1 | High-frequency clock enable |
| asleep | output | 1 | Block is in any non-active state |
| deep_sleep | output | 1 | Deep state is active |
| reject_err | output | 1 | Deep request refused during radio wake-up |
| adc_err | output | 1 | Sticky: deep request refused with ADC enabled |
| pg_fault | output | 1 | Power-good timeout fault |
| wake_done | output | 1 | One-cycle handover pulse to the normal wake |
| wake_was_deep | output | 1 | Last wake came from the deep state |

## Verification
The bench builds the block with its defaults, NWAKE=8 and PG_W=8. It sets `pg_limit` at run time between 1 and 20, so the timeout boundary, one cycle inside the limit and exactly at it, is reached in a few cycles. With eight wake sources, the bench can pair an enabled source bit with other sources that are disabled and show that the disabled ones are ignored. Random mode codes and radio, ADC and power-good timings cover every path of the entry decision.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_IDLE  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_PDOWN = 3'b010;
    localparam logic [MODE_W-1:0] MODE_PSAVE = 3'b011;

    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_LIGHT   = 3'd1,
        ST_DEEP    = 3'd2,
        ST_RESTART = 3'd3,
        ST_RELEASE = 3'd4,
        ST_FAULT   = 3'd5
    } dsp_state_e;

    typedef struct packed {
        dsp_state_e st;
        logic       reject;
        logic       adc_err;
        logic       wake_done;
        logic       wake_deep;
    } dsp_regs_t;
endpackage

// File: rtl/dsp_mode_decode.sv
module dsp_mode_decode
    import dsp_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic              deep_capable
);
    always_comb begin
        deep_capable = (mode == MODE_PDOWN) || (mode == MODE_PSAVE);
    end
endmodule

// File: rtl/dsp_wake_detect.sv
module dsp_wake_detect #(
    parameter int NWAKE = 8
) (
    input  logic [NWAKE-1:0] src,
    input  logic [NWAKE-1:0] en,
    output logic             any_hit
);
    logic [NWAKE-1:0] hit;

    for (genvar i = 0; i < NWAKE; i++) begin : g_hit
        assign hit[i] = src[i] & en[i];
    end

    assign any_hit = |hit;
endmodule

// File: rtl/dsp_pg_timer.sv
module dsp_pg_timer #(
    parameter int PG_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PG_W-1:0] limit,
    output logic            expire
);
    localparam logic [PG_W-1:0] CNT_MAX = {PG_W{1'b1}};

    logic [PG_W-1:0] cnt_d, cnt_q;
    logic [PG_W:0]   cnt_next;

    always_comb begin
        cnt_next = {1'b0, cnt_q} + {{PG_W{1'b0}}, 1'b1};
        cnt_d    = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_next[PG_W-1:0];
        end
        expire = run && (cnt_next >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dsp_deep_sleep_seq.sv
module dsp_deep_sleep_seq
    import dsp_pkg::*;
#(
    parameter int NWAKE = 8,
    parameter int PG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic [MODE_W-1:0] sleep_mode,
    input  logic              radio_sleep,
    input  logic              radio_waking,
    input  logic [NWAKE-1:0]  wake_src,
    input  logic [NWAKE-1:0]  wake_en,
    input  logic              adc_en,
    input  logic              pg_ok,
    input  logic [PG_W-1:0]   pg_limit,
    output logic              dvdd_en,
    output logic              avdd_en,
    output logic              sram_retain,
    output logic              hf_clk_en,
    output logic              asleep,
    output logic              deep_sleep,
    output logic              reject_err,
    output logic              adc_err,
    output logic              pg_fault,
    output logic              wake_done,
    output logic              wake_was_deep
);
    dsp_regs_t r_d, r_q;
    logic      deep_capable;
    logic      wake_any;
    logic      pg_expire;
    logic      in_restart;

    dsp_mode_decode u_mode (
        .mode         (sleep_mode),
        .deep_capable (deep_capable)
    );

    dsp_wake_detect #(.NWAKE(NWAKE)) u_wake (
        .src     (wake_src),
        .en      (wake_en),
        .any_hit (wake_any)
    );

    assign in_restart = (r_q.st == ST_RESTART);

    dsp_pg_timer #(.PG_W(PG_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_restart),
        .limit  (pg_limit),
        .expire (pg_expire)
    );

    always_comb begin
        r_d           = r_q;
        r_d.wake_done = 1'b0;
        r_d.reject    = r_q.reject & radio_waking;
        unique case (r_q.st)
            ST_ACTIVE: begin
                if (sleep_req) begin
                    if (!deep_capable) begin
                        r_d.st = ST_LIGHT;
                    end else if (radio_waking) begin
                        r_d.reject = 1'b1;
                    end else if (!radio_sleep) begin
                        r_d.st = ST_LIGHT;
                    end else if (adc_en) begin
                        r_d.adc_err = 1'b1;
                    end else begin
                        r_d.st = ST_DEEP;
                    end
                end
            end
            ST_LIGHT: begin
                if (wake_any) begin
                    r_d.st        = ST_ACTIVE;
                    r_d.wake_done = 1'b1;
                    r_d.wake_deep = 1'b0;
                end
            end
            ST_DEEP: begin
                if (wake_any) begin
                    r_d.st = ST_RESTART;
                end
            end
            ST_RESTART: begin
                if (pg_ok) begin
                    r_d.st = ST_RELEASE;
                end else if (pg_expire) begin
                    r_d.st = ST_FAULT;
                end
            end
            ST_RELEASE: begin
                r_d.st        = ST_ACTIVE;
                r_d.wake_done = 1'b1;
                r_d.wake_deep = 1'b1;
            end
            ST_FAULT: begin
                r_d.st = ST_FAULT;
            end
            default: begin
                r_d.st = ST_FAULT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_ACTIVE, reject: 1'b0, adc_err: 1'b0,
                     wake_done: 1'b0, wake_deep: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        dvdd_en       = (r_q.st != ST_DEEP);
        avdd_en       = (r_q.st == ST_ACTIVE) || (r_q.st == ST_LIGHT);
        hf_clk_en     = (r_q.st == ST_ACTIVE) || (r_q.st == ST_LIGHT);
        sram_retain   = (r_q.st == ST_DEEP) || (r_q.st == ST_RESTART) ||
                        (r_q.st == ST_FAULT);
        asleep        = (r_q.st != ST_ACTIVE);
        deep_sleep    = (r_q.st == ST_DEEP);
        pg_fault      = (r_q.st == ST_FAULT);
        reject_err    = r_q.reject;
        adc_err       = r_q.adc_err;
        wake_done     = r_q.wake_done;
        wake_was_deep = r_q.wake_deep;
    end
endmodule

// File: rtl/dsp_seq_checker.sv
module dsp_seq_checker
    import dsp_pkg::*;
#(
    parameter int NWAKE = 8,
    parameter int PG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_req,
    input logic [MODE_W-1:0] sleep_mode,
    input logic              radio_sleep,
    input logic              radio_waking,
    input logic [NWAKE-1:0]  wake_src,
    input logic [NWAKE-1:0]  wake_en,
    input logic              adc_en,
    input logic              pg_ok,
    input logic [PG_W-1:0]   pg_limit,
    input logic              dvdd_en,
    input logic              avdd_en,
    input logic              sram_retain,
    input logic              hf_clk_en,
    input logic              asleep,
    input logic              deep_sleep,
    input logic              reject_err,
    input logic              adc_err,
    input logic              pg_fault,
    input logic              wake_done,
    input logic              wake_was_deep
);
    logic deep_mode;
    assign deep_mode = (sleep_mode == MODE_PDOWN) || (sleep_mode == MODE_PSAVE);

    assert_deep_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |-> (!dvdd_en && !avdd_en && sram_retain && !hf_clk_en && asleep));

    assert_reject_waking_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && deep_mode && radio_waking && !asleep) |=> (!asleep && reject_err));

    assert_adc_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && deep_mode && !radio_waking && radio_sleep && adc_en && !asleep)
        |=> (!asleep && adc_err));

    assert_adc_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_err |=> adc_err);

    assert_restart_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dvdd_en) |-> $past(|(wake_src & wake_en)));

    assert_retain_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_retain) |-> (dvdd_en && $past(dvdd_en)));

    assert_handover_pg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_done && wake_was_deep) |-> $past(pg_ok, 2));

    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pg_fault |=> pg_fault);

    assert_fault_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pg_fault |-> (!hf_clk_en && sram_retain && dvdd_en));

    assert_wake_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> (!asleep && hf_clk_en && avdd_en));
endmodule

bind dsp_deep_sleep_seq dsp_seq_checker #(.NWAKE(NWAKE), .PG_W(PG_W)) u_chk (.*);

// File: tb/dsp_deep_sleep_seq_tb.sv
module dsp_deep_sleep_seq_tb;
    localparam int NWAKE = 8;
    localparam int PG_W  = 8;
    localparam int C_LIGHT = 0, C_DEEP = 1, C_REJ = 2, C_ADC = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_req = 1'b0;
    logic [2:0]       sleep_mode = 3'b000;
    logic             radio_sleep = 1'b0;
    logic             radio_waking = 1'b0;
    logic [NWAKE-1:0] wake_src = '0;
    logic [NWAKE-1:0] wake_en = '0;
    logic             adc_en = 1'b0;
    logic             pg_ok = 1'b0;
    logic [PG_W-1:0]  pg_limit = 8'd5;
    logic dvdd_en, avdd_en, sram_retain, hf_clk_en, asleep, deep_sleep;
    logic reject_err, adc_err, pg_fault, wake_done, wake_was_deep;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic exp_adc = 1'b0;

    always #2 clk = ~clk;

    dsp_deep_sleep_seq #(.NWAKE(NWAKE), .PG_W(PG_W)) u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int classify(input logic [2:0] m, input logic rs,
                                    input logic rw, input logic adc);
        if (!(m == 3'b010 || m == 3'b011)) return C_LIGHT;
        if (rw) return C_REJ;
        if (!rs) return C_LIGHT;
        if (adc) return C_ADC;
        return C_DEEP;
    endfunction

    task automatic check_active(input string req);
        check({req, " asleep"}, asleep, 0);
        check({req, " dvdd"}, dvdd_en, 1);
        check({req, " avdd"}, avdd_en, 1);
        check({req, " hfclk"}, hf_clk_en, 1);
        check({req, " retain"}, sram_retain, 0);
    endtask

    task automatic wake_sequence(input bit deep, input int delay);
        int b;
        b = $urandom_range(NWAKE - 1, 0);
        wake_src = NWAKE'(1) << b;
        wake_en = NWAKE'($urandom) & ~(NWAKE'(1) << b);
        tick();
        check("R6 disabled source ignored", asleep, 1);
        check("R6 disabled source keeps retain", sram_retain, deep);
        wake_en = wake_en | (NWAKE'(1) << b);
        tick();
        wake_src = '0;
        if (!deep) begin
            check("R6 light wake", asleep, 0);
            check("R10 wake pulse light", wake_done, 1);
            check("R10 ordinary wake flag", wake_was_deep, 0);
        end else begin
            check("R7 dvdd restored", dvdd_en, 1);
            check("R7 retain held", sram_retain, 1);
            check("R7 hfclk off", hf_clk_en, 0);
            for (int i = 0; i < delay; i++) begin
                tick();
                check("R7 waiting retain", sram_retain, 1);
                check("R9 no early fault", pg_fault, 0);
            end
            pg_ok = 1'b1;
            tick();
            pg_ok = 1'b0;
            check("R8 retain released", sram_retain, 0);
            check("R8 dvdd on", dvdd_en, 1);
            check("R8 not yet handed over", wake_done, 0);
            tick();
            check("R8 handover pulse", wake_done, 1);
            check("R8 active", asleep, 0);
            check("R8 hfclk", hf_clk_en, 1);
            check("R8 avdd", avdd_en, 1);
            check("R10 deep wake flag", wake_was_deep, 1);
        end
        tick();
        check("R10 pulse single", wake_done, 0);
    endtask

    task automatic scenario(input logic [2:0] m, input logic rs, input logic rw,
                            input logic adc, input int lim, input int delay);
        int c;
        c = classify(m, rs, rw, adc);
        pg_limit = PG_W'(lim);
        sleep_req = 1'b1; sleep_mode = m; radio_sleep = rs;
        radio_waking = rw; adc_en = adc;
        tick();
        sleep_req = 1'b0;
        if (c != C_REJ) radio_waking = 1'b0;
        adc_en = 1'b0;
        case (c)
            C_LIGHT: begin
                check("R3 light asleep", asleep, 1);
                check("R3 light dvdd", dvdd_en, 1);
                check("R3 light avdd", avdd_en, 1);
                check("R3 light hfclk", hf_clk_en, 1);
                check("R3 light no retain", sram_retain, 0);
                wake_sequence(0, 0);
            end
            C_DEEP: begin
                check("R2 deep flag", deep_sleep, 1);
                check("R2 dvdd off", dvdd_en, 0);
                check("R2 avdd off", avdd_en, 0);
                check("R2 retain", sram_retain, 1);
                check("R2 hfclk off", hf_clk_en, 0);
                wake_sequence(1, delay);
            end
            C_REJ: begin
                check("R4 stays active", asleep, 0);
                check("R4 reject flag", reject_err, 1);
                tick();
                check("R4 flag held while waking", reject_err, 1);
                radio_waking = 1'b0;
                tick();
                check("R4 flag cleared", reject_err, 0);
            end
            default: begin
                exp_adc = 1'b1;
                check("R5 stays active", asleep, 0);
                check("R5 adc error", adc_err, 1);
            end
        endcase
        check("R5 adc sticky value", adc_err, exp_adc);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check_active("R1 reset");
        check("R1 reset deep", deep_sleep, 0);
        check("R1 reset errors", {reject_err, adc_err, pg_fault}, 0);
        check("R1 reset wake flags", {wake_done, wake_was_deep}, 0);

        scenario(3'b010, 1, 0, 0, 5, 0);
        scenario(3'b000, 1, 0, 0, 5, 0);
        scenario(3'b011, 0, 0, 0, 5, 0);
        scenario(3'b011, 1, 1, 0, 5, 0);
        scenario(3'b011, 1, 0, 0, 5, 4);
        scenario(3'b010, 1, 0, 1, 5, 0);

        for (int k = 0; k < 60; k++) begin
            logic [2:0] m;
            int lim;
            m = ($urandom_range(2, 0) == 0) ? 3'($urandom) :
                (($urandom_range(1, 0) == 0) ? 3'b010 : 3'b011);
            lim = $urandom_range(20, 1);
            scenario(m, 1'($urandom_range(3, 0) != 0), 1'($urandom_range(4, 0) == 0),
                     1'($urandom_range(5, 0) == 0), lim, $urandom_range(lim - 1, 0));
        end

        // R9: pg_ok never arrives, timeout at exactly pg_limit edges
        scenario(3'b010, 1, 0, 0, 5, 0);
        sleep_req = 1'b1; sleep_mode = 3'b010; radio_sleep = 1'b1; pg_limit = 8'd5;
        tick();
        sleep_req = 1'b0;
        check("R2 deep before fault", deep_sleep, 1);
        wake_en = 8'h01; wake_src = 8'h01;
        tick();
        wake_src = '0;
        for (int i = 0; i < 4; i++) tick();
        check("R9 no fault before limit", pg_fault, 0);
        tick();
        check("R9 fault at limit", pg_fault, 1);
        check("R9 fault retain", sram_retain, 1);
        check("R9 fault hfclk off", hf_clk_en, 0);
        pg_ok = 1'b1;
        tick(); tick();
        pg_ok = 1'b0;
        check("R9 fault held", pg_fault, 1);

        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        exp_adc = 1'b0;
        tick();
        check_active("R1 after reset");
        check("R1 adc cleared", adc_err, 0);
        check("R1 fault cleared", pg_fault, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule